// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs the handshake for one 8-bit parallel port so that the port can act either as a strobed input or as a strobed output toward a peripheral. In input mode the peripheral pulls its strobe low to have the pin data captured. The block raises a buffer-full flag, and once the strobe returns high it raises an interrupt request. The host collects the byte over a valid/ready read stream. In output mode the host pushes a byte over a valid/ready write stream. The block drives the byte onto the port pins and pulls an active-low buffer-full line toward the peripheral. The peripheral's acknowledge releases that line, and the end of the acknowledge raises the interrupt request.

The handshake lines sit at fixed positions on a shared 8-bit control port. A parameter selects which of the two position sets the instance uses, called the upper group and the lower group. Interrupts are enabled by single-bit set/reset commands aimed at the control-port position of the strobe or acknowledge pin. A status byte mirrors the control port, with the enable bit shown in place of that pin. All control-port inputs and the pin data are synchronized to `clk`, and edges are found after synchronization.

Stream rules: `rd_valid` stays high while a captured byte is waiting, and `rd_data` holds steady until `rd_ready` completes the transfer. `wr_ready` is low while the output buffer is full, so a write offered then is held off and is neither lost nor accepted.

Top module: `hs_port_ctrl`

## Requirements
- R1: After reset, `rd_valid` is 0, the interrupt pin is 0, the interrupt enable reads 0 in the status byte, and in output mode `wr_ready` is 1 with the active-low buffer-full pin high.
- R2: In input mode, a falling strobe captures `pin_data_in`. Within four clocks, `rd_valid` and the input-full pin (PC5 upper, PC1 lower) are 1 and `rd_data` is the captured byte. `rd_data` then holds until it is read.
- R3: In input mode, the interrupt pin (PC3 upper, PC0 lower) rises after the strobe (PC4 upper, PC2 lower) returns high while the buffer is full and the enable is set. It stays low while the strobe is still low.
- R4: A read transfer (`rd_valid` and `rd_ready` on the same edge) clears `rd_valid`, the input-full pin and the interrupt pin at that edge.
- R5: In output mode, an accepted write drives `wr_data` on `pin_data_out` with `pin_oe` high and pulls the buffer-full pin (PC7 upper, PC1 lower) low. While that pin is low, `wr_ready` is 0 and further writes are not taken.
- R6: In output mode, a falling acknowledge (PC6 upper, PC2 lower) returns the buffer-full pin high. The acknowledge returning high then raises the interrupt pin if the enable is set.
- R7: An accepted write clears the output-mode interrupt pin.
- R8: The interrupt enable is written by a set/reset command whose 3-bit bit number equals the enable position: 4 for upper input, 6 for upper output, 2 for lower. A command for any other bit changes nothing. With the enable at 0, the interrupt pin is 0.
- R9: The handshake pins are driven with `pc_oe` high only at the positions listed in R2 to R6 for the selected group and mode.
- R10: The status byte shows the driven handshake pins at their own positions and the enable at the strobe/acknowledge position. Every other bit is the synchronized `pc_in` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_in | input | 1 | 1 = strobed input mode, 0 = strobed output mode |
| wr_valid | input | 1 | Host write stream valid |
| wr_ready | output | 1 | Host write stream ready (output buffer empty) |
| wr_data | input | 8 | Host write byte |
| rd_valid | output | 1 | Captured byte waiting |
| rd_ready | input | 1 | Host accepts the captured byte |
| rd_data | output | 8 | Captured byte |
| bsr_valid | input | 1 | Control-port bit set/reset command strobe |
| bsr_bit | input | 3 | Bit number of the command |
| bsr_val | input | 1 | 1 = set, 0 = reset |
| pin_data_in | input | 8 | Port pins, peripheral to block |
| pin_data_out | output | 8 | Port pins, block to peripheral |
| pin_oe | output | 1 | Port pin drive enable |
| pc_in | input | 8 | Control-port pins from the peripheral |
| pc_out | output | 8 | Control-port pins driven by the block |
| pc_oe | output | 8 | Per-bit drive enable of the control port |
| status | output | 8 | Status byte |

## Verification
The hardest situation to reach is the interrupt rising at the end of the strobe or acknowledge rather than at its start. Every pin crosses two synchronizer stages and an edge register first, so the stimulus holds the strobe or acknowledge low for several clocks and checks that the interrupt stays low. It then releases the line and checks again after the pipeline has settled. Held-off writes are driven by keeping `wr_valid` high with new data while the buffer is full, and then confirming that the driven byte is unchanged. The lower-group instance is driven with its own strobe position to show that the pin mapping moves with the parameter.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Control-port positions of the handshake lines per group
  function automatic int unsigned stb_pos(input bit lower);
    return lower ? 2 : 4;
  endfunction
  function automatic int unsigned ibf_pos(input bit lower);
    return lower ? 1 : 5;
  endfunction
  function automatic int unsigned intr_pos(input bit lower);
    return lower ? 0 : 3;
  endfunction
  function automatic int unsigned obf_pos(input bit lower);
    return lower ? 1 : 7;
  endfunction
  function automatic int unsigned ack_pos(input bit lower);
    return lower ? 2 : 6;
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_flag_core.sv
module hs_flag_core #(
  parameter int DW = 8,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_in,
  input  logic          hs_line,
  input  logic [DW-1:0] din_sync,
  input  logic [BW-1:0] inte_pos,
  input  logic          bsr_valid,
  input  logic [BW-1:0] bsr_bit,
  input  logic          bsr_val,
  input  logic          wr_fire,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_fire,
  output logic          ibf,
  output logic          obf,
  output logic          inte,
  output logic          intr,
  output logic [DW-1:0] buf_q
);
  logic prev, intr_req;
  logic fall, rise;

  assign fall = prev & ~hs_line;
  assign rise = ~prev & hs_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev     <= 1'b1;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      inte     <= 1'b0;
      intr_req <= 1'b0;
      buf_q    <= '0;
    end else begin
      prev <= hs_line;
      if (bsr_valid && bsr_bit == inte_pos) inte <= bsr_val;
      if (dir_in) begin
        obf <= 1'b0;
        if (rise && ibf) intr_req <= 1'b1;
        if (rd_fire) begin
          ibf      <= 1'b0;
          intr_req <= 1'b0;
        end
        if (fall) begin
          buf_q <= din_sync;
          ibf   <= 1'b1;
        end
      end else begin
        ibf <= 1'b0;
        if (fall) obf <= 1'b0;
        if (rise && !obf) intr_req <= 1'b1;
        if (wr_fire) begin
          buf_q    <= wr_data;
          obf      <= 1'b1;
          intr_req <= 1'b0;
        end
      end
    end
  end

  assign intr = intr_req & inte;
endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl #(
  parameter int DW = 8,
  parameter int PCW = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit LOWER_GROUP = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dir_in,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [DW-1:0]  wr_data,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [DW-1:0]  rd_data,
  input  logic           bsr_valid,
  input  logic [2:0]     bsr_bit,
  input  logic           bsr_val,
  input  logic [DW-1:0]  pin_data_in,
  output logic [DW-1:0]  pin_data_out,
  output logic           pin_oe,
  input  logic [PCW-1:0] pc_in,
  output logic [PCW-1:0] pc_out,
  output logic [PCW-1:0] pc_oe,
  output logic [PCW-1:0] status
);
  import hs_pkg::*;
  localparam int BW = $clog2(PCW);
  localparam int P_STB  = stb_pos(LOWER_GROUP);
  localparam int P_IBF  = ibf_pos(LOWER_GROUP);
  localparam int P_INTR = intr_pos(LOWER_GROUP);
  localparam int P_OBF  = obf_pos(LOWER_GROUP);
  localparam int P_ACK  = ack_pos(LOWER_GROUP);

  logic [PCW-1:0] pc_s;
  logic [DW-1:0]  din_s;
  logic           hs_line, ibf, obf, inte, intr;
  logic [BW-1:0]  inte_pos;
  logic [DW-1:0]  buf_q;
  logic           wr_fire, rd_fire;

  hs_sync #(.W(PCW), .STAGES(SYNC_STAGES), .RST_VAL({PCW{1'b1}})) u_pc_sync (
    .clk(clk), .rst_n(rst_n), .d(pc_in), .q(pc_s));

  hs_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_data_in), .q(din_s));

  assign inte_pos = dir_in ? BW'(P_STB) : BW'(P_ACK);
  assign hs_line  = pc_s[inte_pos];
  assign wr_ready = ~dir_in & ~obf;
  assign wr_fire  = wr_valid & wr_ready;
  assign rd_valid = dir_in & ibf;
  assign rd_fire  = rd_valid & rd_ready;

  hs_flag_core #(.DW(DW), .BW(BW)) u_core (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .hs_line(hs_line),
    .din_sync(din_s), .inte_pos(inte_pos), .bsr_valid(bsr_valid),
    .bsr_bit(bsr_bit[BW-1:0]), .bsr_val(bsr_val), .wr_fire(wr_fire),
    .wr_data(wr_data), .rd_fire(rd_fire), .ibf(ibf), .obf(obf),
    .inte(inte), .intr(intr), .buf_q(buf_q));

  assign rd_data      = buf_q;
  assign pin_data_out = buf_q;
  assign pin_oe       = ~dir_in;

  always_comb begin
    pc_out = '0;
    pc_oe  = '0;
    pc_oe[P_INTR]  = 1'b1;
    pc_out[P_INTR] = intr;
    if (dir_in) begin
      pc_oe[P_IBF]  = 1'b1;
      pc_out[P_IBF] = ibf;
    end else begin
      pc_oe[P_OBF]  = 1'b1;
      pc_out[P_OBF] = ~obf;
    end
  end

  always_comb begin
    for (int i = 0; i < PCW; i++) begin
      if (pc_oe[i])                 status[i] = pc_out[i];
      else if (BW'(i) == inte_pos)  status[i] = inte;
      else                          status[i] = pc_s[i];
    end
  end
endmodule

// File: rtl/hs_port_ctrl_chk.sv
module hs_port_ctrl_chk #(
  parameter int DW = 8,
  parameter int PCW = 8,
  parameter bit LOWER_GROUP = 1'b0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dir_in,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic           rd_valid,
  input logic           rd_ready,
  input logic [DW-1:0]  rd_data,
  input logic [PCW-1:0] pc_out,
  input logic [PCW-1:0] status
);
  import hs_pkg::*;
  localparam int P_INTR = intr_pos(LOWER_GROUP);
  localparam int P_OBF  = obf_pos(LOWER_GROUP);
  localparam int P_STB  = stb_pos(LOWER_GROUP);
  localparam int P_ACK  = ack_pos(LOWER_GROUP);

  logic inte_now;
  assign inte_now = dir_in ? status[P_STB] : status[P_ACK];

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && $stable(dir_in)) |=> $stable(rd_data));

  p_rdclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && $stable(dir_in)) |=> !pc_out[P_INTR]);

  p_bp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_in && !wr_ready) |-> !pc_out[P_OBF]);

  p_wrclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && $stable(dir_in)) |=> !pc_out[P_INTR]);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_out[P_INTR] |-> inte_now);
endmodule

bind hs_port_ctrl hs_port_ctrl_chk #(.DW(DW), .PCW(PCW), .LOWER_GROUP(LOWER_GROUP)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .pc_out(pc_out), .status(status));

// File: tb/hs_port_ctrl_tb.sv
module hs_port_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n = 1'b0, dir_in = 1'b1;
  logic       wr_valid = 1'b0, rd_ready = 1'b0, bsr_valid = 1'b0, bsr_val = 1'b0;
  logic [2:0] bsr_bit = '0;
  logic [7:0] wr_data = '0, pin_data_in = '0, pc_in = 8'hFF;
  logic       wr_ready, rd_valid, pin_oe;
  logic [7:0] rd_data, pin_data_out, pc_out, pc_oe, status;

  logic       rd_ready_b = 1'b0, bsr_valid_b = 1'b0;
  logic [7:0] pc_in_b = 8'hFF, pin_in_b = '0;
  logic       wr_ready_b, rd_valid_b, pin_oe_b;
  logic [7:0] rd_data_b, pin_out_b, pc_out_b, pc_oe_b, status_b;

  hs_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .bsr_valid(bsr_valid),
    .bsr_bit(bsr_bit), .bsr_val(bsr_val), .pin_data_in(pin_data_in),
    .pin_data_out(pin_data_out), .pin_oe(pin_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe), .status(status));

  hs_port_ctrl #(.LOWER_GROUP(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .dir_in(1'b1), .wr_valid(1'b0),
    .wr_ready(wr_ready_b), .wr_data(8'h00), .rd_valid(rd_valid_b),
    .rd_ready(rd_ready_b), .rd_data(rd_data_b), .bsr_valid(bsr_valid_b),
    .bsr_bit(3'd2), .bsr_val(1'b1), .pin_data_in(pin_in_b),
    .pin_data_out(pin_out_b), .pin_oe(pin_oe_b), .pc_in(pc_in_b),
    .pc_out(pc_out_b), .pc_oe(pc_oe_b), .status(status_b));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; dir_in = mode; pc_in = 8'hFF;
    clks(4);
    rst_n = 1'b1;
    clks(1);
  endtask

  task automatic bsr(input logic [2:0] b, input logic v);
    bsr_bit = b; bsr_val = v; bsr_valid = 1'b1;
    clks(1);
    bsr_valid = 1'b0;
    clks(1);
  endtask

  // driver: strobe a byte in and push the expected read value
  task automatic strobe_in(input logic [7:0] d);
    pin_data_in = d;
    clks(1);
    pc_in[4] = 1'b0;
    exp_q.push_back(d);
    clks(5);
  endtask

  task automatic host_read();
    rd_ready = 1'b1;
    clks(1);
    rd_ready = 1'b0;
  endtask

  // monitor: every read transfer is compared against the scoreboard
  always @(posedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) check("R2 unexpected read", rd_data, 8'hxx);
      else check("R2 read data", rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // ---------------- input mode, upper group ----------------
    do_reset(1'b1);
    check("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    check("R1 intr pin", {7'b0, pc_out[3]}, 8'h00);
    check("R1 inte status", {7'b0, status[4]}, 8'h00);
    check("R9 pc_oe input upper", pc_oe, 8'b0010_1000);
    bsr(3'd5, 1'b1); // not the enable position: ignored
    check("R8 other bit ignored", {7'b0, status[4]}, 8'h00);
    bsr(3'd4, 1'b1);
    check("R8 inte set", {7'b0, status[4]}, 8'h01);

    strobe_in(8'hA5);
    check("R2 ibf pin", {7'b0, pc_out[5]}, 8'h01);
    check("R2 rd_valid", {7'b0, rd_valid}, 8'h01);
    check("R3 intr low during strobe", {7'b0, pc_out[3]}, 8'h00);
    pin_data_in = 8'h00;
    clks(3);
    check("R2 rd_data holds", rd_data, 8'hA5);
    pc_in[4] = 1'b1;
    clks(5);
    check("R3 intr after strobe", {7'b0, pc_out[3]}, 8'h01);
    check("R10 status", status & 8'b0011_1000, 8'b0011_1000);
    pc_in[7:6] = 2'b01;
    clks(4);
    check("R10 plain bits", {6'b0, status[7:6]}, 8'h01);
    host_read();
    check("R4 rd_valid clear", {7'b0, rd_valid}, 8'h00);
    check("R4 ibf pin clear", {7'b0, pc_out[5]}, 8'h00);
    check("R4 intr clear", {7'b0, pc_out[3]}, 8'h00);

    // enable off: no interrupt
    bsr(3'd4, 1'b0);
    strobe_in(8'h3C);
    pc_in[4] = 1'b1;
    clks(5);
    check("R8 masked intr", {7'b0, pc_out[3]}, 8'h00);
    bsr(3'd4, 1'b1);
    check("R8 unmask shows pending", {7'b0, pc_out[3]}, 8'h01);
    host_read();
    check("R4 second read", {7'b0, rd_valid}, 8'h00);

    // ---------------- output mode, upper group ----------------
    do_reset(1'b0);
    check("R1 wr_ready", {7'b0, wr_ready}, 8'h01);
    check("R1 obf pin high", {7'b0, pc_out[7]}, 8'h01);
    check("R9 pc_oe output upper", pc_oe, 8'b1000_1000);
    bsr(3'd4, 1'b1); // input-mode position: ignored here
    check("R8 wrong position ignored", {7'b0, status[6]}, 8'h00);
    bsr(3'd6, 1'b1);
    check("R8 inte output set", {7'b0, status[6]}, 8'h01);
    wr_data = 8'h5A; wr_valid = 1'b1;
    clks(1);
    wr_data = 8'hC3; // held off while full
    clks(3);
    check("R5 data out", pin_data_out, 8'h5A);
    check("R5 pin_oe", {7'b0, pin_oe}, 8'h01);
    check("R5 obf pin low", {7'b0, pc_out[7]}, 8'h00);
    check("R5 wr_ready low", {7'b0, wr_ready}, 8'h00);
    wr_valid = 1'b0;
    pc_in[6] = 1'b0;
    clks(5);
    check("R6 obf released", {7'b0, pc_out[7]}, 8'h01);
    check("R6 intr low during ack", {7'b0, pc_out[3]}, 8'h00);
    pc_in[6] = 1'b1;
    clks(5);
    check("R6 intr after ack", {7'b0, pc_out[3]}, 8'h01);
    wr_data = 8'h0F; wr_valid = 1'b1;
    clks(1);
    wr_valid = 1'b0;
    check("R7 intr cleared by write", {7'b0, pc_out[3]}, 8'h00);
    check("R5 new data", pin_data_out, 8'h0F);

    // ---------------- lower group instance ----------------
    do_reset(1'b1);
    bsr_valid_b = 1'b1; clks(1); bsr_valid_b = 1'b0;
    check("R8 lower inte", {7'b0, status_b[2]}, 8'h01);
    check("R9 pc_oe lower", pc_oe_b, 8'b0000_0011);
    pin_in_b = 8'h99; clks(1);
    pc_in_b[2] = 1'b0; clks(5);
    check("R2 lower ibf PC1", {7'b0, pc_out_b[1]}, 8'h01);
    check("R2 lower data", rd_data_b, 8'h99);
    pc_in_b[2] = 1'b1; clks(5);
    check("R3 lower intr PC0", {7'b0, pc_out_b[0]}, 8'h01);
    rd_ready_b = 1'b1; clks(1); rd_ready_b = 1'b0;
    check("R4 lower clear", {6'b0, pc_out_b[1:0]}, 8'h00);

    check("R2 scoreboard empty", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule